// File: doc/BRIEF.md
# Fixed Divide-by-48 Row Mapper

This block turns a linear position, 13 bits wide and ranging over 0 to 8191, into the number of the row that holds it, where every row spans 48 positions. The row number is the position divided by 48 and rounded toward zero. The block never performs a general division. It drops the four low bits of the position, which is an exact divide by 16. The nine bits that remain address a 512-word constant table, and entry N of that table holds N divided by 3, rounded down.

The table contents are computed while the design elaborates. The read is registered, so a result appears one clock after its position is presented, together with a valid flag. Removing the low bits before the lookup keeps the table to 512 words of 8 bits. The result still matches an exact division for every input, because floor(floor(p/16)/3) equals floor(p/48).

The largest row the block can produce is 170, for the last positions in the range, so the output is 8 bits wide.

Top module: `row_div48_mapper`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `out_row` equals floor(`in_pos`/48) of that cycle's position, for each of the 8192 positions.
- R2: `out_valid` is high in a cycle exactly when `in_valid` was high in the previous cycle outside reset, so the latency is one clock.
- R3: While `rst` is high (a synchronous reset, sampled on the rising clock edge), both `out_valid` and `out_row` are 0 after the next rising edge.
- R4: Bits 3:0 of `in_pos` have no effect on the result. Positions that differ only in those bits give the same `out_row`.
- R5: `out_row` never exceeds 170, and position 8191 gives 170.
- R6: At row boundaries, 47 gives 0, 48 gives 1, 8111 gives 168, 8112 gives 169, 8159 gives 169 and 8160 gives 170.
- R7: A cycle with `in_valid` low leaves `out_row` unchanged in the next cycle, whatever `in_pos` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Position on `in_pos` is to be converted |
| in_pos | input | 13 | Linear position, 0 to 8191 |
| out_valid | output | 1 | `out_row` carries a new result |
| out_row | output | 8 | Row number, floor(position/48) |

## Verification
The hard case is a position whose low four bits are not zero and which sits next to a row boundary. There, dropping bits before the divide by 3 is the step that could plausibly be off by one. The stimulus presents every position in turn, so each boundary pair such as 8159 and 8160 is hit with all of its low-bit patterns. At intervals the stimulus inserts idle cycles carrying unrelated positions, to show that the held row is not disturbed. A reset asserted in the middle of the stream, while `in_valid` is still high, shows that the clear takes priority over a pending result.

// File: rtl/rowmap_pkg.sv
package rowmap_pkg;
    localparam int DEF_POS_W  = 13;
    localparam int DEF_SHIFT  = 4;
    localparam int DEF_FACTOR = 3;
    localparam int DEF_ROW_W  = 8;
endpackage

// File: rtl/rowmap_addr_slice.sv
module rowmap_addr_slice #(
    parameter int POS_W  = rowmap_pkg::DEF_POS_W,
    parameter int SHIFT  = rowmap_pkg::DEF_SHIFT,
    localparam int ADDR_W = POS_W - SHIFT
) (
    input  logic [POS_W-1:0]  pos,
    output logic [ADDR_W-1:0] addr
);
    // Exact divide by 2**SHIFT: the low bits are simply dropped.
    always_comb begin
        addr = pos[POS_W-1:SHIFT];
    end
endmodule

// File: rtl/rowmap_rom.sv
module rowmap_rom #(
    parameter int ADDR_W = rowmap_pkg::DEF_POS_W - rowmap_pkg::DEF_SHIFT,
    parameter int FACTOR = rowmap_pkg::DEF_FACTOR,
    parameter int ROW_W  = rowmap_pkg::DEF_ROW_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ROW_W-1:0]  rd_data
);
    logic [ROW_W-1:0] table_w [DEPTH];
    logic [ROW_W-1:0] data_d, data_q;

    // Table contents are fixed at elaboration: entry n holds floor(n/FACTOR).
    for (genvar n = 0; n < DEPTH; n++) begin : g_entry
        assign table_w[n] = ROW_W'(n / FACTOR);
    end

    always_comb begin
        data_d = data_q;
        if (rd_en) begin
            data_d = table_w[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign rd_data = data_q;
endmodule

// File: rtl/row_div48_mapper.sv
module row_div48_mapper #(
    parameter int POS_W  = rowmap_pkg::DEF_POS_W,
    parameter int SHIFT  = rowmap_pkg::DEF_SHIFT,
    parameter int FACTOR = rowmap_pkg::DEF_FACTOR,
    parameter int ROW_W  = rowmap_pkg::DEF_ROW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [POS_W-1:0] in_pos,
    output logic             out_valid,
    output logic [ROW_W-1:0] out_row
);
    localparam int ADDR_W = POS_W - SHIFT;

    typedef struct packed {
        logic vld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [ADDR_W-1:0] addr_w;

    rowmap_addr_slice #(.POS_W(POS_W), .SHIFT(SHIFT)) u_slice (
        .pos  (in_pos),
        .addr (addr_w)
    );

    rowmap_rom #(.ADDR_W(ADDR_W), .FACTOR(FACTOR), .ROW_W(ROW_W)) u_rom (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (in_valid),
        .rd_addr (addr_w),
        .rd_data (out_row)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = in_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_valid = ctl_q.vld;
endmodule

// File: rtl/row_div48_checker.sv
module row_div48_checker #(
    parameter int POS_W  = 13,
    parameter int SHIFT  = 4,
    parameter int FACTOR = 3,
    parameter int ROW_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [POS_W-1:0] in_pos,
    input logic             out_valid,
    input logic [ROW_W-1:0] out_row
);
    localparam int DIVISOR = FACTOR << SHIFT;
    localparam int MAX_ROW = ((1 << POS_W) - 1) / DIVISOR;

    assert_exact_row_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (int'(out_row) == int'($past(in_pos)) / DIVISOR));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_reset_clear_R3: assert property (@(posedge clk)
        rst |=> (!out_valid && out_row == '0));

    assert_row_bound_R5: assert property (@(posedge clk) disable iff (rst)
        int'(out_row) <= MAX_ROW);

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_row));
endmodule

bind row_div48_mapper row_div48_checker #(
    .POS_W(POS_W), .SHIFT(SHIFT), .FACTOR(FACTOR), .ROW_W(ROW_W)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pos(in_pos),
    .out_valid(out_valid), .out_row(out_row)
);

// File: tb/test_row_div48_mapper.sv
module test_row_div48_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [12:0] in_pos = '0;
    logic        out_valid;
    logic [7:0]  out_row;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    row_div48_mapper i_row_div48_mapper (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pos(in_pos),
        .out_valid(out_valid), .out_row(out_row)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        int last_row;
        int row_of_base [512];

        // R3: reset with a pending valid input
        in_valid = 1'b1;
        in_pos   = 13'd8191;
        repeat (3) @(negedge clk);
        check("R3 valid in reset", int'(out_valid), 0);
        check("R3 row in reset", int'(out_row), 0);

        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 idle after reset", int'(out_valid), 0);
        last_row = 0;

        for (int p = 0; p < 8192; p++) begin
            in_valid = 1'b1;
            in_pos   = 13'(p);
            @(negedge clk);
            check("R2 valid latency", int'(out_valid), 1);
            check("R1 row value", int'(out_row), p / 48);
            if ((p % 16) == 0) begin
                row_of_base[p / 16] = int'(out_row);
            end else begin
                check("R4 low bits ignored", int'(out_row), row_of_base[p / 16]);
            end
            if (p == 47 || p == 48 || p == 8111 || p == 8112 || p == 8159 || p == 8160)
                check("R6 boundary", int'(out_row), p / 48);
            if (p == 8191) check("R5 max row", int'(out_row), 170);
            last_row = int'(out_row);

            if ((p % 97) == 5) begin
                in_valid = 1'b0;
                in_pos   = 13'((p * 37 + 4000) % 8192);
                @(negedge clk);
                check("R2 idle valid", int'(out_valid), 0);
                check("R7 row held", int'(out_row), last_row);
            end
        end

        // R3: reset in mid-stream while valid is high
        in_valid = 1'b1;
        in_pos   = 13'd5000;
        rst      = 1'b1;
        @(negedge clk);
        check("R3 mid reset valid", int'(out_valid), 0);
        check("R3 mid reset row", int'(out_row), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", int'(out_row), 5000 / 48);
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule